// File: doc/BRIEF.md
# Character Code Stream Interpreter

This block walks the byte codes of one on-screen-display character row and turns them into one rendering command per character cell. A row is launched with a start address, a four-bit colour selection, a user-glyph enable and a budget of character cells. The block then reads code bytes one at a time from an external code memory and decodes each byte. A byte is either a displayable glyph, a modifier for the next glyph (mirror, flip or accent), a colour change, a one-level jump to another part of the code memory, a return from that jump, a no-operation, or the end of the row.

Each command gives the glyph index and whether the glyph comes from ROM or from user RAM. It also gives the mirror mode, the accent overlay (which code, and how many top slices it covers), the active colour byte taken from a 16-entry lookup table, and a transparency flag for the background. Glyph bitmaps, pixel output and the descriptor logic that launches rows are handled elsewhere.

Top module: `osd_code_interp`

## Requirements
- R1: After reset `row_busy_o`, `mem_rd_o`, `cmd_valid_o` and `err_o` are low, and the block stays idle until `row_start_i`.
- R2: Code 00h and the reserved codes 09h–0Eh and 1Ah–1Fh produce no command and no error; fetching moves to the next address.
- R3: Codes 01h–07h make the next glyph command carry `cmd_mirror_o` equal to the code's low three bits (1 top onto bottom, 2 bottom onto top, 3 horizontal flip, 4 left onto right, 5 right onto left, 6 vertical flip, 7 both flips). The modifier is cleared after that one glyph, and 0 means no mirroring.
- R4: Accent codes E0h–E7h give the next glyph `cmd_acc_slices_o`=5, and E8h–EFh give 3. In both cases `cmd_acc_code_o` is the accent byte. Without an accent both fields are 0, and the accent is cleared after one glyph.
- R5: Bit 3 of `row_clu_i` selects the lookup-table half for the whole row, and bits 2:0 select the starting colour. Codes 10h–17h replace the colour with their low three bits. `cmd_color_o` is table entry {half, colour}, that is byte `clut_i[8*idx +: 8]`. `cmd_transp_o` is 1 when that byte's bit 7 is 1 and bits 6:4 are 0.
- R6: Codes 20h–DFh are ROM glyphs (`cmd_udc_o`=0). For codes F0h–FFh, `cmd_udc_o` equals the row's `row_udc_en_i`.
- R7: A jump code 18h or 19h holds target bit 9 in its bit 0. The following byte holds target bits 8:1, and bit 0 of the target is 0. The jump emits a space (20h) command, and fetching continues at the target. Code 08h emits a space and resumes two bytes after the jump code.
- R8: A jump while a return is still pending raises `err_o` for one cycle and skips both the jump code and its address byte. A return with no pending jump raises `err_o` and emits nothing.
- R9: A modifier, colour, jump or return code arriving while a modifier is pending raises `err_o` and is ignored. The pending modifier stays in force.
- R10: Code 0Fh ends the row: `row_busy_o` falls and no further reads are made.
- R11: Each command uses one cell. The row ends after `row_cells_i` commands, and a start with zero cells is ignored.
- R12: `mem_rd_o` is never high in two consecutive cycles. Data is taken on `mem_data_i` in the cycle after the read.

Verification notes are below the port table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start_i | input | 1 | Launch a row (taken when idle) |
| row_base_i | input | CODE_AW | Address of the first code byte |
| row_clu_i | input | 4 | Table half (bit 3) and starting colour |
| row_udc_en_i | input | 1 | Codes F0h–FFh come from user RAM |
| row_cells_i | input | CELL_W | Character cell budget for the row |
| clut_i | input | 128 | Sixteen colour bytes, entry n at bits 8n+7:8n |
| mem_rd_o | output | 1 | Code memory read strobe |
| mem_addr_o | output | CODE_AW | Code memory read address |
| mem_data_i | input | 8 | Code byte, valid the cycle after the read |
| row_busy_o | output | 1 | Row in progress |
| cmd_valid_o | output | 1 | Command fields valid this cycle |
| cmd_glyph_o | output | 8 | Glyph index |
| cmd_udc_o | output | 1 | Glyph from user RAM |
| cmd_mirror_o | output | 3 | Mirror mode, 0 none |
| cmd_acc_slices_o | output | 3 | Accent top-slice count, 0, 3 or 5 |
| cmd_acc_code_o | output | 8 | Accent glyph code, 0 if none |
| cmd_color_o | output | 8 | Active colour byte |
| cmd_transp_o | output | 1 | Background transparent |
| err_o | output | 1 | One-cycle pulse on a misplaced code |

## Verification
The hardest state to reach is a jump arriving while the single return register is still in use. This only happens inside a jumped-to region, so the stimulus lays out a code memory in which the jump target itself contains a second jump. It then checks that the space is not emitted, the address byte is skipped, and the later return still lands after the first jump. Two adjacent modifiers and a return with no pending jump are placed in memory in the same way. Cell-budget exhaustion is forced with a row that has no end code.

// File: rtl/osd_cs_pkg.sv
package osd_cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_DATA, S_REQ_LO, S_DATA_LO
  } state_e;

  typedef enum logic [3:0] {
    K_NOP, K_MIRROR, K_RTN, K_EOL, K_COLOR, K_CALL, K_ACCENT, K_ROM, K_HIGH
  } kind_e;

  localparam logic [7:0] SPACE_CODE  = 8'h20;
  localparam logic [2:0] ACC_LOWER   = 3'd5;
  localparam logic [2:0] ACC_UPPER   = 3'd3;
  localparam int         CALL_AW     = 10;
endpackage

// File: rtl/osd_cs_classify.sv
module osd_cs_classify
  import osd_cs_pkg::*;
(
  input  logic [7:0] code_i,
  output kind_e      kind_o,
  output logic       ctrl_o
);
  always_comb begin
    kind_o = K_NOP;
    if (code_i >= 8'h01 && code_i <= 8'h07)      kind_o = K_MIRROR;
    else if (code_i == 8'h08)                    kind_o = K_RTN;
    else if (code_i == 8'h0F)                    kind_o = K_EOL;
    else if (code_i >= 8'h10 && code_i <= 8'h17) kind_o = K_COLOR;
    else if (code_i == 8'h18 || code_i == 8'h19) kind_o = K_CALL;
    else if (code_i >= 8'h20 && code_i <= 8'hDF) kind_o = K_ROM;
    else if (code_i >= 8'hE0 && code_i <= 8'hEF) kind_o = K_ACCENT;
    else if (code_i >= 8'hF0)                    kind_o = K_HIGH;
  end

  assign ctrl_o = (kind_o == K_MIRROR) || (kind_o == K_RTN) || (kind_o == K_COLOR)
               || (kind_o == K_CALL)   || (kind_o == K_ACCENT);
endmodule

// File: rtl/osd_cs_color.sv
module osd_cs_color #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*8-1:0] table_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [7:0]           color_o,
  output logic                 transp_o
);
  logic [7:0] entry [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign entry[g] = table_i[g*8 +: 8];
  end

  assign color_o  = entry[idx_i];
  // shadow bit set and all background bits clear
  assign transp_o = color_o[7] && (color_o[6:4] == 3'b000);
endmodule

// File: rtl/osd_code_interp.sv
module osd_code_interp
  import osd_cs_pkg::*;
#(
  parameter int CODE_AW = 10,
  parameter int CELL_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_start_i,
  input  logic [CODE_AW-1:0] row_base_i,
  input  logic [3:0]         row_clu_i,
  input  logic               row_udc_en_i,
  input  logic [CELL_W-1:0]  row_cells_i,
  input  logic [127:0]       clut_i,
  output logic               mem_rd_o,
  output logic [CODE_AW-1:0] mem_addr_o,
  input  logic [7:0]         mem_data_i,
  output logic               row_busy_o,
  output logic               cmd_valid_o,
  output logic [7:0]         cmd_glyph_o,
  output logic               cmd_udc_o,
  output logic [2:0]         cmd_mirror_o,
  output logic [2:0]         cmd_acc_slices_o,
  output logic [7:0]         cmd_acc_code_o,
  output logic [7:0]         cmd_color_o,
  output logic               cmd_transp_o,
  output logic               err_o
);
  localparam logic [CODE_AW-1:0] ONE = CODE_AW'(1);
  localparam logic [CODE_AW-1:0] TWO = CODE_AW'(2);

  state_e             state_q, state_d;
  logic [CODE_AW-1:0] addr_q, addr_d, ret_q, ret_d;
  logic               ret_vld_q, ret_vld_d;
  logic               blk_q, blk_d, udc_en_q, udc_en_d;
  logic [2:0]         col_q, col_d;
  logic [CELL_W-1:0]  cells_q, cells_d;
  logic [2:0]         pmir_q, pmir_d, pslc_q, pslc_d;
  logic [7:0]         pacc_q, pacc_d;
  logic               a9_q, a9_d;
  logic               cv_q, cv_d, cudc_q, cudc_d, err_q, err_d;
  logic [7:0]         cgl_q, cgl_d, cacc_q, cacc_d;
  logic [2:0]         cmir_q, cmir_d, cslc_q, cslc_d;
  logic [3:0]         cidx_q, cidx_d;

  kind_e              kind;
  logic               is_ctrl, pending, emit;
  logic [CODE_AW-1:0] target;

  osd_cs_classify u_cls (.code_i(mem_data_i), .kind_o(kind), .ctrl_o(is_ctrl));

  osd_cs_color #(.ENTRIES(16)) u_col (
    .table_i(clut_i), .idx_i(cidx_q), .color_o(cmd_color_o), .transp_o(cmd_transp_o)
  );

  assign pending = (pmir_q != 3'd0) || (pslc_q != 3'd0);

  always_comb begin
    target = '0;
    target[CALL_AW-1:0] = {a9_q, mem_data_i, 1'b0};
  end

  always_comb begin
    state_d = state_q;  addr_d = addr_q;  ret_d = ret_q;  ret_vld_d = ret_vld_q;
    blk_d = blk_q;  udc_en_d = udc_en_q;  col_d = col_q;  cells_d = cells_q;
    pmir_d = pmir_q;  pslc_d = pslc_q;  pacc_d = pacc_q;  a9_d = a9_q;
    cgl_d = cgl_q;  cudc_d = cudc_q;  cmir_d = cmir_q;  cslc_d = cslc_q;
    cacc_d = cacc_q;  cidx_d = cidx_q;
    cv_d = 1'b0;  err_d = 1'b0;  emit = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (row_start_i && row_cells_i != '0) begin
          state_d = S_REQ;  addr_d = row_base_i;  cells_d = row_cells_i;
          blk_d = row_clu_i[3];  col_d = row_clu_i[2:0];  udc_en_d = row_udc_en_i;
          ret_vld_d = 1'b0;  pmir_d = '0;  pslc_d = '0;  pacc_d = '0;
        end
      end
      S_REQ:    state_d = S_DATA;
      S_REQ_LO: state_d = S_DATA_LO;
      S_DATA: begin
        state_d = S_REQ;
        addr_d  = addr_q + ONE;
        if (is_ctrl && pending) begin
          err_d = 1'b1;
          if (kind == K_CALL) addr_d = addr_q + TWO;
        end else begin
          unique case (kind)
            K_MIRROR: pmir_d = mem_data_i[2:0];
            K_COLOR:  col_d  = mem_data_i[2:0];
            K_ACCENT: begin
              pslc_d = mem_data_i[3] ? ACC_UPPER : ACC_LOWER;
              pacc_d = mem_data_i;
            end
            K_EOL:    state_d = S_IDLE;
            K_RTN: begin
              if (ret_vld_q) begin
                emit = 1'b1;  cgl_d = SPACE_CODE;  cudc_d = 1'b0;
                cmir_d = '0;  cslc_d = '0;  cacc_d = '0;
                addr_d = ret_q;  ret_vld_d = 1'b0;
              end else begin
                err_d = 1'b1;
              end
            end
            K_CALL: begin
              if (ret_vld_q) begin
                err_d = 1'b1;  addr_d = addr_q + TWO;
              end else begin
                a9_d = mem_data_i[0];  state_d = S_REQ_LO;
              end
            end
            K_ROM, K_HIGH: begin
              emit = 1'b1;  cgl_d = mem_data_i;
              cudc_d = (kind == K_HIGH) && udc_en_q;
              cmir_d = pmir_q;  cslc_d = pslc_q;  cacc_d = pacc_q;
              pmir_d = '0;  pslc_d = '0;  pacc_d = '0;
            end
            default: ;
          endcase
        end
      end
      S_DATA_LO: begin
        state_d = S_REQ;
        ret_d = addr_q + ONE;  ret_vld_d = 1'b1;  addr_d = target;
        emit = 1'b1;  cgl_d = SPACE_CODE;  cudc_d = 1'b0;
        cmir_d = '0;  cslc_d = '0;  cacc_d = '0;
      end
      default: state_d = S_IDLE;
    endcase
    if (emit) begin
      cv_d    = 1'b1;
      cidx_d  = {blk_q, col_q};
      cells_d = cells_q - CELL_W'(1);
      if (cells_q == CELL_W'(1)) state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  addr_q <= '0;  ret_q <= '0;  ret_vld_q <= 1'b0;
      blk_q <= 1'b0;  udc_en_q <= 1'b0;  col_q <= '0;  cells_q <= '0;
      pmir_q <= '0;  pslc_q <= '0;  pacc_q <= '0;  a9_q <= 1'b0;
      cv_q <= 1'b0;  cgl_q <= '0;  cudc_q <= 1'b0;  cmir_q <= '0;
      cslc_q <= '0;  cacc_q <= '0;  cidx_q <= '0;  err_q <= 1'b0;
    end else begin
      state_q <= state_d;  addr_q <= addr_d;  ret_q <= ret_d;  ret_vld_q <= ret_vld_d;
      blk_q <= blk_d;  udc_en_q <= udc_en_d;  col_q <= col_d;  cells_q <= cells_d;
      pmir_q <= pmir_d;  pslc_q <= pslc_d;  pacc_q <= pacc_d;  a9_q <= a9_d;
      cv_q <= cv_d;  cgl_q <= cgl_d;  cudc_q <= cudc_d;  cmir_q <= cmir_d;
      cslc_q <= cslc_d;  cacc_q <= cacc_d;  cidx_q <= cidx_d;  err_q <= err_d;
    end
  end

  assign mem_rd_o         = (state_q == S_REQ) || (state_q == S_REQ_LO);
  assign mem_addr_o       = addr_q;
  assign row_busy_o       = (state_q != S_IDLE);
  assign cmd_valid_o      = cv_q;
  assign cmd_glyph_o      = cgl_q;
  assign cmd_udc_o        = cudc_q;
  assign cmd_mirror_o     = cmir_q;
  assign cmd_acc_slices_o = cslc_q;
  assign cmd_acc_code_o   = cacc_q;
  assign err_o            = err_q;

  p_no_back_to_back_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !row_busy_o |-> !mem_rd_o);
  p_zero_cells_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_busy_o && row_start_i && row_cells_i == '0) |=> !row_busy_o);
  p_jump_emits_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA_LO) |=> (cmd_valid_o && cmd_glyph_o == SPACE_CODE && ret_vld_q));
  p_one_modifier_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((pmir_q != 3'd0) && (pslc_q != 3'd0)));
  p_modifier_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_glyph_o != SPACE_CODE) |-> (pmir_q == 3'd0 && pslc_q == 3'd0));
  p_accent_span_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_acc_slices_o == 3'd0 || cmd_acc_slices_o == ACC_UPPER
                     || cmd_acc_slices_o == ACC_LOWER));
endmodule

// File: tb/osd_code_interp_tb.sv
`timescale 1ns/1ps
module osd_code_interp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        row_start_i;
  logic [9:0]  row_base_i;
  logic [3:0]  row_clu_i;
  logic        row_udc_en_i;
  logic [7:0]  row_cells_i;
  logic [127:0] clut_i;
  logic        mem_rd_o;
  logic [9:0]  mem_addr_o;
  logic [7:0]  mem_data_i;
  logic        row_busy_o, cmd_valid_o, cmd_udc_o, cmd_transp_o, err_o;
  logic [7:0]  cmd_glyph_o, cmd_acc_code_o, cmd_color_o;
  logic [2:0]  cmd_mirror_o, cmd_acc_slices_o;

  always #2.5 clk = ~clk;

  osd_code_interp dut_i (.*);

  logic [7:0]  mem [1024];
  logic [31:0] rec [16];
  int ncmd, nrd, n_cmp, n_bad;
  bit err_seen, done;

  always @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o) nrd++;
      if (err_o) err_seen = 1'b1;
      if (cmd_valid_o) begin
        if (ncmd < 16)
          rec[ncmd] = {cmd_udc_o, cmd_mirror_o, cmd_acc_slices_o, cmd_transp_o,
                       cmd_acc_code_o, cmd_color_o, cmd_glyph_o};
        ncmd++;
      end
    end
  end

  function automatic logic [7:0] cl(input logic [3:0] idx);
    return {idx, ~idx};
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] g, input logic u, input logic [2:0] m,
                                     input logic [2:0] s, input logic [7:0] a, input logic [3:0] idx);
    return {u, m, s, (idx == 4'd8), a, cl(idx), g};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_row(input logic [9:0] base, input logic [3:0] clu, input logic udc,
                         input logic [7:0] cells);
    @(negedge clk);
    ncmd = 0; nrd = 0; err_seen = 1'b0;
    row_base_i = base; row_clu_i = clu; row_udc_en_i = udc; row_cells_i = cells;
    row_start_i = 1'b1;
    @(negedge clk);
    row_start_i = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!row_busy_o) break;
    end
    @(negedge clk);
  endtask

  // {prefix, char, clu, udc, exp glyph, exp udc, exp mirror, exp slices, exp accent, exp index}
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'h41, 4'h0, 1'b0, 8'h41, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0},
    {8'h03, 8'h42, 4'h2, 1'b0, 8'h42, 1'b0, 3'd3, 3'd0, 8'h00, 4'h2},
    {8'h07, 8'h43, 4'h9, 1'b0, 8'h43, 1'b0, 3'd7, 3'd0, 8'h00, 4'h9},
    {8'h01, 8'h44, 4'h0, 1'b0, 8'h44, 1'b0, 3'd1, 3'd0, 8'h00, 4'h0},
    {8'hE2, 8'h65, 4'h0, 1'b0, 8'h65, 1'b0, 3'd0, 3'd5, 8'hE2, 4'h0},
    {8'hEA, 8'h45, 4'h1, 1'b0, 8'h45, 1'b0, 3'd0, 3'd3, 8'hEA, 4'h1},
    {8'h15, 8'h46, 4'h8, 1'b0, 8'h46, 1'b0, 3'd0, 3'd0, 8'h00, 4'hD},
    {8'h12, 8'h47, 4'h0, 1'b0, 8'h47, 1'b0, 3'd0, 3'd0, 8'h00, 4'h2},
    {8'h00, 8'hF3, 4'h0, 1'b1, 8'hF3, 1'b1, 3'd0, 3'd0, 8'h00, 4'h0},
    {8'h00, 8'hF3, 4'h0, 1'b0, 8'hF3, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0},
    {8'h00, 8'hFF, 4'h5, 1'b1, 8'hFF, 1'b1, 3'd0, 3'd0, 8'h00, 4'h5},
    {8'h00, 8'h20, 4'h8, 1'b0, 8'h20, 1'b0, 3'd0, 3'd0, 8'h00, 4'h8}
  };

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    n_cmp = 0; n_bad = 0; ncmd = 0; nrd = 0; err_seen = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h0F;
    for (int i = 0; i < 16; i++) clut_i[i*8 +: 8] = cl(4'(i));
    rst_n = 1'b0; row_start_i = 1'b0; row_base_i = '0; row_clu_i = '0;
    row_udc_en_i = 1'b0; row_cells_i = '0;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk({row_busy_o, mem_rd_o, cmd_valid_o, err_o} == 4'b0, "R1 reset outputs",
        {28'h0, row_busy_o, mem_rd_o, cmd_valid_o, err_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!row_busy_o && nrd == 0, "R1 idle without start", 32'(nrd), 32'h0);

    // Vector walk: prefix, glyph, end code (R2..R6, R10)
    for (int v = 0; v < NV; v++) begin
      mem[0] = VEC[v][47:40]; mem[1] = VEC[v][39:32]; mem[2] = 8'h0F;
      run_row(10'h000, VEC[v][31:28], VEC[v][27], 8'd8);
      e = mk(VEC[v][26:19], VEC[v][18], VEC[v][17:15], VEC[v][14:12], VEC[v][11:4], VEC[v][3:0]);
      chk(ncmd == 1, "R10 one command per vector row", 32'(ncmd), 32'd1);
      chk(rec[0] == e, "R3 R4 R5 R6 command fields", rec[0], e);
      chk(!err_seen && nrd == 3, "R2 R10 reads then stop", 32'(nrd), 32'd3);
    end

    // R2: reserved codes skipped silently
    mem[0] = 8'h0A; mem[1] = 8'h1C; mem[2] = 8'h41; mem[3] = 8'h0F;
    run_row(10'h000, 4'h0, 1'b0, 8'd8);
    e = mk(8'h41, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0);
    chk(ncmd == 1 && rec[0] == e && !err_seen, "R2 reserved codes", rec[0], e);

    // R7: jump and return
    mem[10'h100] = 8'h41; mem[10'h101] = 8'h19; mem[10'h102] = 8'h40;
    mem[10'h103] = 8'h43; mem[10'h104] = 8'h0F;
    mem[10'h280] = 8'h42; mem[10'h281] = 8'h08;
    run_row(10'h100, 4'h3, 1'b0, 8'd16);
    chk(ncmd == 5 && !err_seen, "R7 jump command count", 32'(ncmd), 32'd5);
    e = mk(8'h20, 1'b0, 3'd0, 3'd0, 8'h00, 4'h3);
    chk(rec[1] == e, "R7 jump space", rec[1], e);
    e = mk(8'h42, 1'b0, 3'd0, 3'd0, 8'h00, 4'h3);
    chk(rec[2] == e, "R7 jump target", rec[2], e);
    e = mk(8'h20, 1'b0, 3'd0, 3'd0, 8'h00, 4'h3);
    chk(rec[3] == e, "R7 return space", rec[3], e);
    e = mk(8'h43, 1'b0, 3'd0, 3'd0, 8'h00, 4'h3);
    chk(rec[4] == e, "R7 resume after address byte", rec[4], e);

    // R8: jump while return pending
    mem[10'h200] = 8'h41; mem[10'h201] = 8'h18; mem[10'h202] = 8'h98; mem[10'h203] = 8'h0F;
    mem[10'h130] = 8'h42; mem[10'h131] = 8'h18; mem[10'h132] = 8'hAA;
    mem[10'h133] = 8'h43; mem[10'h134] = 8'h08;
    run_row(10'h200, 4'h0, 1'b0, 8'd16);
    chk(err_seen, "R8 nested jump flagged", {31'h0, err_seen}, 32'h1);
    e = mk(8'h43, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0);
    chk(ncmd == 5 && rec[3] == e, "R8 nested jump skipped", rec[3], e);
    e = mk(8'h20, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0);
    chk(rec[4] == e, "R8 return still valid", rec[4], e);

    // R8: return without jump
    mem[0] = 8'h08; mem[1] = 8'h41; mem[2] = 8'h0F;
    run_row(10'h000, 4'h0, 1'b0, 8'd8);
    chk(err_seen && ncmd == 1, "R8 stray return", 32'(ncmd), 32'd1);

    // R9: second modifier ignored, first kept then cleared
    mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h44; mem[3] = 8'h45; mem[4] = 8'h0F;
    run_row(10'h000, 4'h0, 1'b0, 8'd8);
    chk(err_seen && ncmd == 2, "R9 conflict flagged", 32'(ncmd), 32'd2);
    e = mk(8'h44, 1'b0, 3'd1, 3'd0, 8'h00, 4'h0);
    chk(rec[0] == e, "R9 first modifier kept", rec[0], e);
    e = mk(8'h45, 1'b0, 3'd0, 3'd0, 8'h00, 4'h0);
    chk(rec[1] == e, "R3 modifier cleared", rec[1], e);

    // R11, R12: cell budget without end code
    mem[0] = 8'h41; mem[1] = 8'h42; mem[2] = 8'h43; mem[3] = 8'h44; mem[4] = 8'h45;
    run_row(10'h000, 4'h0, 1'b0, 8'd3);
    chk(ncmd == 3 && !row_busy_o, "R11 budget ends row", 32'(ncmd), 32'd3);
    chk(nrd == 3, "R12 one read per code byte", 32'(nrd), 32'd3);

    // R11: zero cells
    run_row(10'h000, 4'h0, 1'b0, 8'd0);
    chk(ncmd == 0 && nrd == 0, "R11 zero cells ignored", 32'(nrd), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule